// File: doc/BRIEF.md
# Packed Unsigned Multiply-High Unit

This block multiplies two vectors lane by lane, each lane an unsigned 16-bit integer. Every lane pair forms a 32-bit product, and only the upper half of that product is written to the matching result lane. A two-bit mode input picks the operating width and the operand form. The two legacy modes are destructive: the old destination value serves as the first source. The two extended modes read two independent sources. Above the active width, the result either carries the old destination bits unchanged or is cleared to zero, depending on the mode.

The unit is a two-stage pipeline with a valid/ready handshake on both sides. A stall at the output freezes both stages. One illegal combination is defined: the 128-bit extended mode with its length bit set. This combination produces no arithmetic result. The unit instead returns the old destination untouched, with an undefined-operation flag raised.

Top module: `pmulhu_unit`

## Requirements
- R1: Each active result lane i (bits 16i+15:16i) equals bits 31:16 of the unsigned product of lane i of the first source and lane i of `in_src_b`.
- R2: Exact corner products: 0xFFFF times 0xFFFF gives 0xFFFE, and any lane value times 0x0000 or 0x0001 gives 0x0000.
- R3: Mode 2'b00 (legacy 64-bit) takes the first source from `in_dst` and ignores `in_src_a`. It computes lanes 0..3, and result bits 255:64 equal `in_dst`.
- R4: Mode 2'b01 (legacy 128-bit) takes the first source from `in_dst` and ignores `in_src_a`. It computes lanes 0..7, and result bits 255:128 equal `in_dst`.
- R5: Mode 2'b10 with `in_len`=0 (extended 128-bit) takes `in_src_a` and `in_src_b`. It computes lanes 0..7, and result bits 255:128 are zero.
- R6: Mode 2'b11 (256-bit) takes `in_src_a` and `in_src_b` and computes all 16 lanes. `in_len` has no effect.
- R7: Mode 2'b10 with `in_len`=1 returns `out_undef`=1 and `out_result` equal to `in_dst` unchanged. In every other mode, `out_undef` is 0, and `in_len` has no effect in modes 2'b00 and 2'b01.
- R8: With `out_ready` held high, a transfer accepted at one rising edge shows `out_valid` low after that edge and high after the next one. Results leave in acceptance order, and none is lost.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `out_result` and `out_undef` stay unchanged.
- R10: During reset, `out_valid` and `out_undef` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Unit can take an operand set |
| in_mode | input | 2 | 00 legacy 64, 01 legacy 128 merge, 10 extended 128 zero, 11 256 |
| in_len | input | 1 | Length bit; illegal when set in mode 10 |
| in_src_a | input | 256 | First source for the extended modes |
| in_src_b | input | 256 | Second source |
| in_dst | input | 256 | Old destination value; first source in the legacy modes |
| out_valid | output | 1 | Result presented |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 256 | New destination value |
| out_undef | output | 1 | Undefined-operation flag for this result |

## Verification
The assertions assume that the consumer follows the handshake: a stalled result is not dropped, and `out_ready` is a plain level that the unit cannot see ahead of time. They also assume that the mode and length inputs are only meaningful together with `in_valid`. The stimulus changes every input only at falling clock edges. It raises `in_valid` at random, and it withdraws or keeps `out_ready` at random, which includes long stalls. The random operands are biased toward lanes of 0, 1 and 0xFFFF, so that each mode meets the corner products.

// File: rtl/pmulhu_unit.sv
module pmulhu_unit #(
  parameter int LW = 16,
  parameter int VW = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    in_mode,
  input  logic          in_len,
  input  logic [VW-1:0] in_src_a,
  input  logic [VW-1:0] in_src_b,
  input  logic [VW-1:0] in_dst,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [VW-1:0] out_result,
  output logic          out_undef
);
  localparam int NL   = VW / LW;
  localparam int PW   = 2 * LW;
  localparam int N64  = 64 / LW;
  localparam int N128 = 128 / LW;
  localparam int H128 = N128 * LW;
  localparam logic [1:0] M_L64 = 2'd0, M_L128 = 2'd1, M_V128 = 2'd2, M_V256 = 2'd3;

  logic          s1_valid, s1_undef;
  logic [1:0]    s1_mode;
  logic [VW-1:0] s1_a, s1_b, s1_old;
  logic [VW-1:0] hi, merged;
  logic [1:0]    o_mode;
  logic          adv;

  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      out_valid <= 1'b0;
      out_undef <= 1'b0;
    end else if (adv) begin
      s1_valid  <= in_valid;
      out_valid <= s1_valid;
      out_undef <= s1_valid && s1_undef;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      s1_a       <= (in_mode == M_L64 || in_mode == M_L128) ? in_dst : in_src_a;
      s1_b       <= in_src_b;
      s1_old     <= in_dst;
      s1_mode    <= in_mode;
      s1_undef   <= (in_mode == M_V128) && in_len;
      out_result <= merged;
      o_mode     <= s1_mode;
    end
  end

  for (genvar g = 0; g < NL; g++) begin : g_lane
    localparam bit IN64  = (g < N64);
    localparam bit IN128 = (g < N128);
    logic [PW-1:0] prod;
    logic          act;
    assign prod = {{LW{1'b0}}, s1_a[g*LW +: LW]} * {{LW{1'b0}}, s1_b[g*LW +: LW]};
    assign hi[g*LW +: LW] = prod[PW-1:LW];
    assign act = (s1_mode == M_L64)  ? IN64 :
                 (s1_mode == M_V256) ? 1'b1 : IN128;
    assign merged[g*LW +: LW] = s1_undef ? s1_old[g*LW +: LW] :
                                act      ? hi[g*LW +: LW] :
                                (s1_mode == M_V128) ? {LW{1'b0}} : s1_old[g*LW +: LW];
  end

  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_undef));

  a_r8_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(s1_valid));

  a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_undef && o_mode == M_V128 |-> out_result[VW-1:H128] == '0);

  a_r7_undef_mode: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_undef |-> o_mode == M_V128);

  a_r10_reset: assert property (@(posedge clk)
    !rst_n |=> !out_valid && !out_undef);
endmodule

// File: tb/sim_pmulhu_unit.sv
module sim_pmulhu_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, in_len = 1'b0, out_valid, out_ready = 1'b0, out_undef;
  logic [1:0] in_mode = 2'd0;
  logic [255:0] in_src_a = '0, in_src_b = '0, in_dst = '0, out_result;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [259:0] sb[$];
  logic [255:0] last_res, held_res;
  logic last_undef, held = 0;

  always #4 clk = ~clk;

  pmulhu_unit u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_len(in_len), .in_src_a(in_src_a), .in_src_b(in_src_b),
    .in_dst(in_dst), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_undef(out_undef));

  task automatic chk(input bit ok, input string req, input logic [256:0] act, input logic [256:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [256:0] model(input logic [1:0] m, input logic ln,
      input logic [255:0] a, input logic [255:0] b, input logic [255:0] old);
    logic [255:0] r, x;
    logic [31:0] p;
    int n;
    if (m == 2'd2 && ln) return {1'b1, old};
    x = (m < 2'd2) ? old : a;
    n = (m == 2'd0) ? 4 : (m == 2'd3) ? 16 : 8;
    r = (m == 2'd2) ? '0 : old;
    for (int i = 0; i < n; i++) begin
      p = {16'h0, x[i*16 +: 16]} * {16'h0, b[i*16 +: 16]};
      r[i*16 +: 16] = p[31:16];
    end
    return {1'b0, r};
  endfunction

  function automatic string req_of(input logic [1:0] m, input logic ln);
    case (m)
      2'd0: return "R3/R1";
      2'd1: return "R4/R1";
      2'd2: return ln ? "R7" : "R5/R1";
      default: return "R6/R1";
    endcase
  endfunction

  function automatic logic [255:0] rvec();
    logic [255:0] v;
    for (int i = 0; i < 16; i++) begin
      case ($urandom % 8)
        0: v[i*16 +: 16] = 16'h0000;
        1: v[i*16 +: 16] = 16'h0001;
        2: v[i*16 +: 16] = 16'hFFFF;
        default: v[i*16 +: 16] = 16'($urandom);
      endcase
    end
    return v;
  endfunction

  task automatic step(input logic iv, input logic [1:0] m, input logic ln,
      input logic [255:0] a, input logic [255:0] b, input logic [255:0] o, input logic ordy);
    logic [259:0] e;
    in_valid = iv; in_mode = m; in_len = ln; in_src_a = a; in_src_b = b; in_dst = o;
    out_ready = ordy;
    #1;
    if (held)
      chk(out_valid && out_result == held_res, "R9 hold", {out_undef, out_result}, {1'b0, held_res});
    held = out_valid && !ordy;
    held_res = out_result;
    if (held) chk(!in_ready, "R9 in_ready", {256'h0, in_ready}, 257'h0);
    if (out_valid && ordy) begin
      if (sb.size() == 0) chk(0, "R8 extra result", {out_undef, out_result}, 257'h0);
      else begin
        e = sb.pop_front();
        chk({out_undef, out_result} == e[256:0], req_of(e[259:258], e[257]),
            {out_undef, out_result}, e[256:0]);
        last_res = out_result;
        last_undef = out_undef;
      end
    end
    if (iv && in_ready) sb.push_back({m, ln, model(m, ln, a, b, o)});
    @(negedge clk);
  endtask

  task automatic drain();
    for (int i = 0; i < 4; i++) step(0, 2'd0, 0, '0, '0, '0, 1);
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [255:0] a, b, o;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!out_valid && !out_undef && in_ready, "R10 reset",
        {254'h0, out_valid, out_undef, in_ready}, 257'h1);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 latency with out_ready high
    a = rvec(); b = rvec(); o = rvec();
    step(1, 2'd3, 0, a, b, o, 1);
    chk(!out_valid, "R8 after one edge", {256'h0, out_valid}, 257'h0);
    step(0, 2'd0, 0, '0, '0, '0, 1);
    chk(out_valid, "R8 after two edges", {256'h0, out_valid}, 257'h1);
    drain();

    // R2 corner lanes in 256-bit mode
    a = '0; b = '0;
    a[15:0] = 16'hFFFF; b[15:0] = 16'hFFFF;
    a[31:16] = 16'h1234; b[31:16] = 16'h0000;
    a[47:32] = 16'hABCD; b[47:32] = 16'h0001;
    a[255:240] = 16'hFFFF; b[255:240] = 16'h0001;
    step(1, 2'd3, 1, a, b, {256{1'b1}}, 1);
    drain();
    chk(last_res[15:0] == 16'hFFFE, "R2 ffff*ffff", {241'h0, last_res[15:0]}, 257'hFFFE);
    chk(last_res[31:16] == 16'h0, "R2 times zero", {241'h0, last_res[31:16]}, 257'h0);
    chk(last_res[47:32] == 16'h0, "R2 times one", {241'h0, last_res[47:32]}, 257'h0);
    chk(last_res[255:240] == 16'h0, "R2 top lane times one", {241'h0, last_res[255:240]}, 257'h0);

    // R7 illegal length: destination untouched
    o = rvec();
    step(1, 2'd2, 1, rvec(), rvec(), o, 1);
    drain();
    chk(last_undef && last_res == o, "R7 undef keeps dst", {last_undef, last_res}, {1'b1, o});

    // R3 legacy 64: src_a ignored, upper kept
    o = rvec(); b = rvec();
    step(1, 2'd0, 1, {256{1'b1}}, b, o, 1);
    drain();
    chk(last_res[255:64] == o[255:64] && !last_undef, "R3 upper kept",
        {1'b0, last_res}, model(2'd0, 1, '0, b, o));

    // R9 stall hold
    step(1, 2'd1, 0, rvec(), rvec(), rvec(), 0);
    for (int i = 0; i < 6; i++) step(0, 2'd0, 0, '0, '0, '0, 0);
    drain();

    // random mix
    for (int i = 0; i < 1500; i++)
      step(($urandom % 4) != 0, 2'($urandom), 1'($urandom), rvec(), rvec(), rvec(),
           ($urandom % 3) != 0);
    for (int i = 0; i < 6; i++) step(0, 2'd0, 0, '0, '0, '0, 1);
    chk(sb.size() == 0, "R8 none lost", 257'(sb.size()), 257'h0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule